// File: doc/BRIEF.md
# Flash Status and Busy Controller

This block keeps the self-timed operation state of a page-buffered serial flash. A command decoder hands it array operation requests: page-to-buffer transfer, page-to-buffer compare, buffer program with erase, buffer program without erase, page erase, block erase, program through a buffer, and auto rewrite. Each accepted request holds the device busy for a cycle count taken from its duration class. The durations are plain counters; no cells are erased or programmed. The active-low `busy_n` output follows the busy state. A compare records its result when it finishes.

While `stat_en` is high, the status byte comes out one bit at a time on `stat_bit`. It starts at bit 7, and each `stat_shift` pulse moves one bit lower. After bit 0 it wraps back to bit 7. Every bit is taken from the state at the moment it is shown, so a host that stops shifting at bit 7 sees it change from 0 to 1 when the operation ends. Two kinds of request are refused: one that arrives while an operation runs, and one that would modify a protected low page while `wp_n` is low. A refused request starts nothing and sets a sticky `rejected` flag.

The control is a two-state machine. `ST_IDLE` moves to `ST_BUSY` on an accepted request (the *accept* transition). `ST_BUSY` returns to `ST_IDLE` after its final busy cycle (the *finish* transition). A low `rst_n` forces `ST_IDLE` from either state (the *abort* transition).

Top module: `fsc_status_busy`

## Requirements
- R1: After reset, `busy_n` is 1 and `rejected` is 0, and the status byte reads 8'b1011_0000.
- R2: The status byte is laid out as follows. Bit 7 is 1 when ready and 0 when busy. Bit 6 is the last compare result. Bits 5:3 hold the density code 3'b110. Bits 2:0 read 0.
- R3: `stat_bit` shows bit 7 in the cycle `stat_en` rises. Each cycle in which `stat_shift` is high moves the output to the next lower bit at the following edge, and bit 0 is followed by bit 7. `stat_bit` is 0 while `stat_en` is low.
- R4: Every bit shown reflects the current state. With shifting stopped at bit 7, `stat_bit` is 0 for each busy cycle and becomes 1 in the first ready cycle.
- R5: An accepted request drives `busy_n` low from the next cycle for exactly D cycles. D is T_XFER for transfer and compare, T_EP for program with erase, program through a buffer and auto rewrite, T_PROG for program without erase, T_PERASE for page erase, and T_BERASE for block erase.
- R6: `op_kind` codes are 0 transfer, 1 compare, 2 program with erase, 3 program without erase, 4 page erase, 5 block erase, 6 program through a buffer, and 7 auto rewrite. Codes 2 to 7 modify the array.
- R7: When a compare finishes, status bit 6 takes the value of `cmp_diff` sampled in the final busy cycle. Bit 6 is 1 when the data differed and 0 when it matched. No other operation changes bit 6.
- R8: A request made while busy is dropped and sets `rejected`. The running operation still ends on time.
- R9: While `wp_n` is 0, a modifying request (code 2 to 7) whose `op_page` is below PROT_PAGES is refused: busy does not start and `rejected` is set. Transfer and compare are never refused for protection. With `wp_n` at 1, no page is protected.
- R10: A low `rst_n` aborts a running operation at once and drives `busy_n` to 1.
- R11: Once set, `rejected` stays 1 until reset, including across later accepted operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Array operation request strobe |
| op_kind | input | 3 | Operation code (R6) |
| op_page | input | PAGE_W | Target page; for block erase, any page in the block |
| cmp_diff | input | 1 | Compare outcome from the array, 1 = differs |
| wp_n | input | 1 | Active-low write protect of the low pages |
| stat_en | input | 1 | Status read in progress |
| stat_shift | input | 1 | Advance to the next status bit |
| busy_n | output | 1 | Active-low busy indication |
| stat_bit | output | 1 | Serial status bit |
| rejected | output | 1 | Sticky refused-request flag |

## Verification
The bench builds the block with PAGE_W=5 and PROT_PAGES=8. The five durations are set to 3, 7, 5, 4 and 6 cycles. With these values every operation code can be swept against both write-protect levels and against pages on each side of the protection limit, including the last page. Each busy window can be counted cycle by cycle against its class. Short windows make it cheap to poll bit 7, to read two full status bytes in a row, to interrupt an operation with a second request, and to reset in mid-operation.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        OP_XFER      = 3'd0,
        OP_CMP       = 3'd1,
        OP_PROG_ERS  = 3'd2,
        OP_PROG_ONLY = 3'd3,
        OP_PG_ERASE  = 3'd4,
        OP_BLK_ERASE = 3'd5,
        OP_THRU_BUF  = 3'd6,
        OP_REWRITE   = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        CL_XFER,
        CL_EP,
        CL_PROG,
        CL_PERASE,
        CL_BERASE
    } dur_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } ctl_state_e;

    localparam logic [2:0] DENSITY_CODE = 3'b110;

endpackage

// File: rtl/fsc_op_decode.sv
module fsc_op_decode
    import fsc_pkg::*;
#(
    parameter int PAGE_W     = 13,
    parameter int PROT_PAGES = 256
) (
    input  logic [2:0]        op_kind,
    input  logic [PAGE_W-1:0] op_page,
    input  logic              wp_n,
    output dur_class_e        dur_class,
    output logic              is_cmp,
    output logic              refused
);
    localparam logic [PAGE_W:0] PROT_LIM = (PAGE_W+1)'(PROT_PAGES);

    logic modifies;
    logic low_page;

    always_comb begin
        unique case (op_kind_e'(op_kind))
            OP_XFER, OP_CMP:                     dur_class = CL_XFER;
            OP_PROG_ERS, OP_THRU_BUF, OP_REWRITE: dur_class = CL_EP;
            OP_PROG_ONLY:                        dur_class = CL_PROG;
            OP_PG_ERASE:                         dur_class = CL_PERASE;
            OP_BLK_ERASE:                        dur_class = CL_BERASE;
            default:                             dur_class = CL_XFER;
        endcase
    end

    assign is_cmp   = (op_kind == OP_CMP);
    assign modifies = op_kind[2] | op_kind[1];
    assign low_page = ({1'b0, op_page} < PROT_LIM);
    assign refused  = modifies && low_page && !wp_n;

endmodule

// File: rtl/fsc_busy_timer.sv
module fsc_busy_timer
    import fsc_pkg::*;
#(
    parameter int T_XFER   = 8750,
    parameter int T_EP     = 500000,
    parameter int T_PROG   = 375000,
    parameter int T_PERASE = 250000,
    parameter int T_BERASE = 375000,
    parameter int CNT_W    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  dur_class_e cls,
    input  logic       run,
    output logic       last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (cls)
            CL_XFER:   load_val = CNT_W'(T_XFER - 1);
            CL_EP:     load_val = CNT_W'(T_EP - 1);
            CL_PROG:   load_val = CNT_W'(T_PROG - 1);
            CL_PERASE: load_val = CNT_W'(T_PERASE - 1);
            CL_BERASE: load_val = CNT_W'(T_BERASE - 1);
            default:   load_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/fsc_stat_serial.sv
module fsc_stat_serial (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_en,
    input  logic       stat_shift,
    input  logic [7:0] stat_byte,
    output logic       stat_bit
);
    logic [2:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= 3'd7;
        else if (!stat_en)
            idx_q <= 3'd7;
        else if (stat_shift)
            idx_q <= idx_q - 3'd1;
    end

    assign stat_bit = stat_en & stat_byte[idx_q];

endmodule

// File: rtl/fsc_status_busy.sv
module fsc_status_busy
    import fsc_pkg::*;
#(
    parameter int PAGE_W     = 13,
    parameter int PROT_PAGES = 256,
    parameter int T_XFER     = 8750,
    parameter int T_EP       = 500000,
    parameter int T_PROG     = 375000,
    parameter int T_PERASE   = 250000,
    parameter int T_BERASE   = 375000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [2:0]        op_kind,
    input  logic [PAGE_W-1:0] op_page,
    input  logic              cmp_diff,
    input  logic              wp_n,
    input  logic              stat_en,
    input  logic              stat_shift,
    output logic              busy_n,
    output logic              stat_bit,
    output logic              rejected
);
    localparam int MAX_A = (T_XFER > T_EP) ? T_XFER : T_EP;
    localparam int MAX_B = (T_PROG > T_PERASE) ? T_PROG : T_PERASE;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D = (MAX_C > T_BERASE) ? MAX_C : T_BERASE;
    localparam int CNT_W = $clog2(MAX_D + 1);

    ctl_state_e state_q, state_nx;
    dur_class_e req_class;
    logic       req_is_cmp, req_refused;
    logic       accept, reject_ev, tmr_last;
    logic       run_cmp_q, cmp_q, rej_q;
    logic [7:0] stat_byte;

    fsc_op_decode #(.PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES)) u_dec (
        .op_kind   (op_kind),
        .op_page   (op_page),
        .wp_n      (wp_n),
        .dur_class (req_class),
        .is_cmp    (req_is_cmp),
        .refused   (req_refused)
    );

    fsc_busy_timer #(
        .T_XFER(T_XFER), .T_EP(T_EP), .T_PROG(T_PROG),
        .T_PERASE(T_PERASE), .T_BERASE(T_BERASE), .CNT_W(CNT_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .cls   (req_class),
        .run   (state_q == ST_BUSY),
        .last  (tmr_last)
    );

    assign accept    = (state_q == ST_IDLE) && op_start && !req_refused;
    assign reject_ev = op_start && ((state_q == ST_BUSY) || req_refused);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)   state_nx = ST_BUSY;
            ST_BUSY: if (tmr_last) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            run_cmp_q <= 1'b0;
            cmp_q     <= 1'b0;
            rej_q     <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept)
                run_cmp_q <= req_is_cmp;
            if (state_q == ST_BUSY && tmr_last && run_cmp_q)
                cmp_q <= cmp_diff;
            if (reject_ev)
                rej_q <= 1'b1;
        end
    end

    always_comb begin
        busy_n    = (state_q == ST_IDLE);
        rejected  = rej_q;
        stat_byte = {busy_n, cmp_q, DENSITY_CODE, 3'b000};
    end

    fsc_stat_serial u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_en    (stat_en),
        .stat_shift (stat_shift),
        .stat_byte  (stat_byte),
        .stat_bit   (stat_bit)
    );

endmodule

// File: rtl/fsc_status_busy_chk.sv
module fsc_status_busy_chk #(
    parameter int PAGE_W     = 13,
    parameter int PROT_PAGES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic [2:0]        op_kind,
    input logic [PAGE_W-1:0] op_page,
    input logic              wp_n,
    input logic              stat_en,
    input logic              busy_n,
    input logic              stat_bit,
    input logic              rejected,
    input logic              cmp_q
);
    localparam logic [PAGE_W:0] LIM = (PAGE_W+1)'(PROT_PAGES);

    logic guarded;
    assign guarded = (op_kind[2] | op_kind[1]) && !wp_n && ({1'b0, op_page} < LIM);

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && !busy_n |=> rejected);

    // R11
    rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |=> rejected);

    // R3
    ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> !stat_bit);

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy_n) |-> $stable(cmp_q));

    // R9
    prot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && busy_n && guarded |=> busy_n && rejected);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && busy_n && !guarded |=> !busy_n);

endmodule

bind fsc_status_busy fsc_status_busy_chk #(.PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_page  (op_page),
    .wp_n     (wp_n),
    .stat_en  (stat_en),
    .busy_n   (busy_n),
    .stat_bit (stat_bit),
    .rejected (rejected),
    .cmp_q    (cmp_q)
);

// File: tb/fsc_status_busy_test.sv
module fsc_status_busy_test;

    localparam int PW = 5;
    localparam int PROT = 8;
    localparam int TX = 3, TEP = 7, TP = 5, TPE = 4, TBE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0;
    logic [2:0] op_kind = 3'd0;
    logic [PW-1:0] op_page = '0;
    logic cmp_diff = 1'b0;
    logic wp_n = 1'b1;
    logic stat_en = 1'b0;
    logic stat_shift = 1'b0;
    logic busy_n, stat_bit, rejected;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fsc_status_busy #(
        .PAGE_W(PW), .PROT_PAGES(PROT), .T_XFER(TX), .T_EP(TEP),
        .T_PROG(TP), .T_PERASE(TPE), .T_BERASE(TBE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_page(op_page), .cmp_diff(cmp_diff), .wp_n(wp_n),
        .stat_en(stat_en), .stat_shift(stat_shift), .busy_n(busy_n),
        .stat_bit(stat_bit), .rejected(rejected)
    );

    function automatic int dur_of(input int k);
        case (k)
            0, 1:    return TX;
            2, 6, 7: return TEP;
            3:       return TP;
            4:       return TPE;
            default: return TBE;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_start = 1'b0; stat_en = 1'b0; stat_shift = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int k, input int pg, input bit wp, output int n);
        @(negedge clk);
        op_kind = 3'(k); op_page = PW'(pg); wp_n = wp; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        n = 0;
        while (busy_n == 1'b0 && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_bits(input int cnt, output logic [15:0] b);
        b = '0;
        @(negedge clk);
        stat_en = 1'b1; stat_shift = 1'b1;
        for (int i = cnt - 1; i >= 0; i--) begin
            #1 b[i] = stat_bit;
            @(negedge clk);
        end
        stat_en = 1'b0; stat_shift = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] b;
        int pages [4] = '{0, 7, 8, 31};

        do_reset();
        // R1 reset state
        chk("R1 busy_n", int'(busy_n), 1);
        chk("R1 rejected", int'(rejected), 0);
        #1 chk("R3 bit while disabled", int'(stat_bit), 0);
        // R1 R2 R3 two repetitions of the byte
        read_bits(16, b);
        chk("R2 R3 status byte twice", int'(b), 16'hB0B0);

        // R5 R6 R9 sweep of kinds, protect levels, pages
        for (int k = 0; k < 8; k++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 4; p++) begin
                    bit refuse;
                    do_reset();
                    refuse = (k >= 2) && (w == 0) && (pages[p] < PROT);
                    issue(k, pages[p], bit'(w), n);
                    chk($sformatf("R5 R9 busy len k%0d wp%0d pg%0d", k, w, pages[p]),
                        n, refuse ? 0 : dur_of(k));
                    chk($sformatf("R9 reject k%0d wp%0d pg%0d", k, w, pages[p]),
                        int'(rejected), refuse ? 1 : 0);
                end

        // R7 compare result set, cleared, and left alone by a transfer
        do_reset();
        cmp_diff = 1'b1;
        issue(1, 3, 1'b1, n);
        read_bits(8, b);
        chk("R7 mismatch bit6", int'(b[7:0]), 8'hF0);
        cmp_diff = 1'b0;
        issue(1, 3, 1'b1, n);
        read_bits(8, b);
        chk("R7 match bit6", int'(b[7:0]), 8'hB0);
        cmp_diff = 1'b1;
        issue(0, 3, 1'b1, n);
        read_bits(8, b);
        chk("R7 transfer leaves bit6", int'(b[7:0]), 8'hB0);
        cmp_diff = 1'b0;

        // R4 polling bit 7 during a block erase
        do_reset();
        @(negedge clk);
        op_kind = 3'd5; op_page = PW'(20); wp_n = 1'b1; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0; stat_en = 1'b1;
        n = 0;
        for (int i = 0; i < TBE; i++) begin
            #1 if (stat_bit == 1'b0) n++;
            @(negedge clk);
        end
        chk("R4 bit7 low while busy", n, TBE);
        #1 chk("R4 bit7 high when ready", int'(stat_bit), 1);
        stat_en = 1'b0;

        // R8 request during busy is dropped, length unchanged
        do_reset();
        @(negedge clk);
        op_kind = 3'd5; op_page = PW'(20); op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b1; op_kind = 3'd0;
        n = 1;
        @(negedge clk);
        op_start = 1'b0;
        while (busy_n == 1'b0 && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk("R8 busy length unchanged", n, TBE);
        chk("R8 rejected set", int'(rejected), 1);
        // R11 sticky across an accepted operation
        issue(0, 1, 1'b1, n);
        chk("R11 op still runs", n, TX);
        chk("R11 rejected stays", int'(rejected), 1);

        // R10 reset aborts a running operation
        do_reset();
        @(negedge clk);
        op_kind = 3'd2; op_page = PW'(12); op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        @(negedge clk);
        chk("R10 busy before abort", int'(busy_n), 0);
        rst_n = 1'b0;
        #1 chk("R10 busy_n after abort", int'(busy_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 stays idle", int'(busy_n), 1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule